// File: doc/BRIEF.md
# Receiver Enable and FIFO Clear Synchronizer

This block is the control slice of a serial peripheral that spans two clock domains. On the bus side it accepts writes that carry a two-bit FIFO flush code and a receiver-enable bit. On the core side it produces single-cycle flush strobes for the transmit and receive FIFOs and a receiver-enable level. Requests that must reach the core domain travel over a toggle handshake. While a handshake is outstanding, a busy flag is raised and any further write is dropped.

Turning the receiver off always acts at once. The bus-side enable bit clears on the write. The core-side enable level drops in the same cycle. The block also emits a receive-buffer flush pulse and an overflow-flag clear pulse. Turning the receiver on behaves in one of two ways. If the peripheral's module enable is low, the bit takes effect at once and no busy period follows. If the module enable is high, the write starts a handshake, and busy holds until the core domain runs the receiver. The module-enable write lock does not apply to either field.

Top module: `rxc_ctrl_sync`

## Requirements
- R1: After reset, the read-back enable bit, the read-back flush code, busy, the flush and overflow-clear pulses, both FIFO strobes and the core enable level are all 0.
- R2: A flush code is counted only on an accepted write. Code 1 yields exactly one core-clock pulse on the TX strobe. Code 2 yields exactly one on the RX strobe. Code 3 yields one on each. Code 0 yields none and on its own starts no busy period.
- R3: While a flush request is pending, the read-back flush code equals the written code. It returns to 0 in the same cycle that busy falls.
- R4: An accepted write with enable bit 0 clears the read-back enable bit and the core enable level on the next bus cycle. It also gives exactly one bus-cycle pulse on both the receive flush output and the overflow-clear output.
- R5: An accepted write with enable bit 1 while the module enable is 0 sets the read-back enable bit on the next bus cycle. It raises no busy unless the flush code is nonzero.
- R6: An accepted write with enable bit 1 while the module enable is 1 raises busy on the next bus cycle. During busy the enable bit reads 1. Busy falls only once the core enable level is 1.
- R7: Every busy period spans at least 4 rising core-clock edges.
- R8: A write presented while busy is high has no effect. It changes neither field and produces no pulse or strobe.
- R9: The module enable blocks neither field. Flush codes and disable writes act the same with it at 0 or 1.
- R10: Once the enable bit reads 1, the core enable level reaches 1 within 8 core cycles, whatever the module enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus_i | input | 1 | Register interface clock |
| rst_bus_n_i | input | 1 | Asynchronous active-low reset, bus domain |
| clk_core_i | input | 1 | Serial core clock |
| rst_core_n_i | input | 1 | Asynchronous active-low reset, core domain |
| wr_en_i | input | 1 | Write strobe for the control fields |
| wr_fclr_i | input | 2 | Flush code: 0 none, 1 TX, 2 RX, 3 both |
| wr_rxen_i | input | 1 | Receiver enable value being written |
| mod_en_i | input | 1 | Peripheral module enable state |
| rd_rxen_o | output | 1 | Read-back of the receiver enable bit |
| rd_fclr_o | output | 2 | Read-back of the flush code |
| sync_busy_o | output | 1 | Handshake to core domain in progress |
| rx_flush_o | output | 1 | Receive-buffer flush pulse, bus domain |
| ovf_clr_o | output | 1 | Overflow status clear pulse, bus domain |
| core_tx_clr_o | output | 1 | TX FIFO clear strobe, core domain |
| core_rx_clr_o | output | 1 | RX FIFO clear strobe, core domain |
| core_rx_en_o | output | 1 | Receiver enable level into the core domain |

## Verification
A FIFO flush and a receiver enable can share one write, and therefore one handshake. The core must then fire the strobes for the code and also wait for the enable level before it acknowledges. The bench sweeps every flush code against both enable values and both module-enable states. For each combination it counts the strobes on the core clock, counts core edges while busy is high, and checks at the instant busy falls that the core enable is already high. A disable combined with a flush code puts the immediate flush pulses in the same cycle as the launch of a request. The bench judges that case by requiring one pulse on each bus-side output and the strobes for the code.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_TX   = 2'd1,
    FC_RX   = 2'd2,
    FC_BOTH = 2'd3
  } fclr_e;

  localparam int unsigned FCLR_W      = 2;
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/rxc_rst_sync.sv
module rxc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_async_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] shreg_d;

  always_comb begin
    shreg_d = {shreg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_async_n_i) begin
    if (!rst_async_n_i) shreg_q <= '0;
    else                shreg_q <= shreg_d;
  end

  assign rst_n_o = shreg_q[STAGES-1];

endmodule

// File: rtl/rxc_sync.sv
module rxc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rxc_bus_ctl.sv
module rxc_bus_ctl
  import rxc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [FCLR_W-1:0] wr_fclr_i,
  input  logic              wr_rxen_i,
  input  logic              mod_en_i,
  input  logic              ack_tgl_s_i,
  output logic              req_tgl_o,
  output logic [FCLR_W-1:0] pay_fclr_o,
  output logic              pay_en_o,
  output logic              rxen_o,
  output logic              busy_o,
  output logic              rx_flush_o,
  output logic              ovf_clr_o
);

  logic              req_q, req_d;
  logic              busy_q, busy_d;
  logic              rxen_q, rxen_d;
  logic              paen_q, paen_d;
  logic [FCLR_W-1:0] fclr_q, fclr_d;
  logic              flush_q, flush_d;
  logic              ovfc_q, ovfc_d;

  logic accept, launch, done;

  always_comb begin
    accept  = wr_en_i & ~busy_q;
    launch  = accept & ((wr_fclr_i != FC_NONE) | (wr_rxen_i & mod_en_i));
    done    = busy_q & (ack_tgl_s_i == req_q);

    req_d   = req_q;
    busy_d  = busy_q;
    rxen_d  = rxen_q;
    paen_d  = paen_q;
    fclr_d  = fclr_q;
    flush_d = 1'b0;
    ovfc_d  = 1'b0;

    if (accept) begin
      rxen_d  = wr_rxen_i;
      flush_d = ~wr_rxen_i;
      ovfc_d  = ~wr_rxen_i;
    end

    if (launch) begin
      req_d  = ~req_q;
      busy_d = 1'b1;
      fclr_d = wr_fclr_i;
      paen_d = wr_rxen_i & mod_en_i;
    end else if (done) begin
      busy_d = 1'b0;
      fclr_d = FC_NONE;
      paen_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      req_q   <= 1'b0;
      busy_q  <= 1'b0;
      rxen_q  <= 1'b0;
      paen_q  <= 1'b0;
      fclr_q  <= FC_NONE;
      flush_q <= 1'b0;
      ovfc_q  <= 1'b0;
    end else begin
      req_q   <= req_d;
      busy_q  <= busy_d;
      rxen_q  <= rxen_d;
      paen_q  <= paen_d;
      fclr_q  <= fclr_d;
      flush_q <= flush_d;
      ovfc_q  <= ovfc_d;
    end
  end

  assign req_tgl_o  = req_q;
  assign pay_fclr_o = fclr_q;
  assign pay_en_o   = paen_q;
  assign rxen_o     = rxen_q;
  assign busy_o     = busy_q;
  assign rx_flush_o = flush_q;
  assign ovf_clr_o  = ovfc_q;

  // R4: a flush pulse is only ever seen with the enable bit already off
  assert_flush_off_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    flush_q |-> !rxen_q);

  // R3: with no request pending the flush code reads zero
  assert_idle_fclr_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !busy_q |-> (fclr_q == FC_NONE));

  // R8: a write during busy leaves the enable bit and flush code untouched
  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_q && wr_en_i) |=> ($stable(rxen_q) && !flush_q));

  // R6: enabling while the module runs raises busy and reads back 1
  assert_enable_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && !busy_q && wr_rxen_i && mod_en_i) |=> (busy_q && rxen_q));

endmodule

// File: rtl/rxc_core_resp.sv
module rxc_core_resp
  import rxc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              req_tgl_s_i,
  input  logic              en_s_i,
  input  logic [FCLR_W-1:0] pay_fclr_i,
  input  logic              pay_en_i,
  output logic              ack_tgl_o,
  output logic              tx_clr_o,
  output logic              rx_clr_o
);

  logic seen_q, seen_d;
  logic ack_q, ack_d;
  logic txc_q, txc_d;
  logic rxc_q, rxc_d;
  logic new_req, ready;

  always_comb begin
    new_req = req_tgl_s_i ^ seen_q;
    ready   = (ack_q != seen_q) & (~pay_en_i | en_s_i);
    seen_d  = req_tgl_s_i;
    txc_d   = new_req & pay_fclr_i[0];
    rxc_d   = new_req & pay_fclr_i[1];
    ack_d   = ready ? seen_q : ack_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      seen_q <= 1'b0;
      ack_q  <= 1'b0;
      txc_q  <= 1'b0;
      rxc_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      ack_q  <= ack_d;
      txc_q  <= txc_d;
      rxc_q  <= rxc_d;
    end
  end

  assign ack_tgl_o = ack_q;
  assign tx_clr_o  = txc_q;
  assign rx_clr_o  = rxc_q;

  // R2: each strobe lasts a single core cycle
  assert_tx_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    txc_q |=> !txc_q);
  assert_rx_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rxc_q |=> !rxc_q);

  // R6: an acknowledge for an enable request is never returned before the level arrived
  assert_ack_after_en_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ack_q != $past(ack_q)) |-> (!$past(pay_en_i) || $past(en_s_i)));

endmodule

// File: rtl/rxc_ctrl_sync.sv
module rxc_ctrl_sync
  import rxc_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic              clk_bus_i,
  input  logic              rst_bus_n_i,
  input  logic              clk_core_i,
  input  logic              rst_core_n_i,
  input  logic              wr_en_i,
  input  logic [FCLR_W-1:0] wr_fclr_i,
  input  logic              wr_rxen_i,
  input  logic              mod_en_i,
  output logic              rd_rxen_o,
  output logic [FCLR_W-1:0] rd_fclr_o,
  output logic              sync_busy_o,
  output logic              rx_flush_o,
  output logic              ovf_clr_o,
  output logic              core_tx_clr_o,
  output logic              core_rx_clr_o,
  output logic              core_rx_en_o
);

  localparam int unsigned FWD_W = 2;

  logic              bus_rst_n, core_rst_n;
  logic              req_tgl, ack_tgl, ack_tgl_s;
  logic              rxen_lvl, en_s, req_s;
  logic              pay_en, busy;
  logic [FCLR_W-1:0] pay_fclr;
  logic [FWD_W-1:0]  fwd_s;

  rxc_rst_sync #(.STAGES(STAGES)) u_rst_bus (
    .clk_i(clk_bus_i), .rst_async_n_i(rst_bus_n_i), .rst_n_o(bus_rst_n));

  rxc_rst_sync #(.STAGES(STAGES)) u_rst_core (
    .clk_i(clk_core_i), .rst_async_n_i(rst_core_n_i), .rst_n_o(core_rst_n));

  rxc_bus_ctl u_bus (
    .clk_i       (clk_bus_i),
    .rst_n_i     (bus_rst_n),
    .wr_en_i     (wr_en_i),
    .wr_fclr_i   (wr_fclr_i),
    .wr_rxen_i   (wr_rxen_i),
    .mod_en_i    (mod_en_i),
    .ack_tgl_s_i (ack_tgl_s),
    .req_tgl_o   (req_tgl),
    .pay_fclr_o  (pay_fclr),
    .pay_en_o    (pay_en),
    .rxen_o      (rxen_lvl),
    .busy_o      (busy),
    .rx_flush_o  (rx_flush_o),
    .ovf_clr_o   (ovf_clr_o)
  );

  rxc_sync #(.W(FWD_W), .STAGES(STAGES)) u_fwd (
    .clk_i(clk_core_i), .rst_n_i(core_rst_n),
    .d_i({rxen_lvl, req_tgl}), .q_o(fwd_s));

  assign req_s = fwd_s[0];
  assign en_s  = fwd_s[1];

  rxc_core_resp u_core (
    .clk_i       (clk_core_i),
    .rst_n_i     (core_rst_n),
    .req_tgl_s_i (req_s),
    .en_s_i      (en_s),
    .pay_fclr_i  (pay_fclr),
    .pay_en_i    (pay_en),
    .ack_tgl_o   (ack_tgl),
    .tx_clr_o    (core_tx_clr_o),
    .rx_clr_o    (core_rx_clr_o)
  );

  rxc_sync #(.W(1), .STAGES(STAGES)) u_back (
    .clk_i(clk_bus_i), .rst_n_i(bus_rst_n),
    .d_i(ack_tgl), .q_o(ack_tgl_s));

  // off-going enable bypasses the synchronizer so the receiver stops at once
  assign core_rx_en_o = en_s & rxen_lvl;
  assign rd_rxen_o    = rxen_lvl;
  assign rd_fclr_o    = pay_fclr;
  assign sync_busy_o  = busy;

  // R6: when busy drops with the enable bit set, the core is already running
  assert_release_en_R6: assert property (@(posedge clk_bus_i) disable iff (!bus_rst_n)
    ($fell(busy) && rxen_lvl) |-> core_rx_en_o);

endmodule

// File: tb/rxc_ctrl_sync_tb.sv
`timescale 1ns/1ps
module rxc_ctrl_sync_tb_top;

  logic       clk_bus = 1'b0;
  logic       clk_core = 1'b0;
  logic       rst_bus_n = 1'b0;
  logic       rst_core_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_fclr = 2'd0;
  logic       wr_rxen = 1'b0;
  logic       mod_en = 1'b0;
  logic       rd_rxen, sync_busy, rx_flush, ovf_clr;
  logic       core_tx_clr, core_rx_clr, core_rx_en;
  logic [1:0] rd_fclr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int tx_cnt = 0, rx_cnt = 0, fl_cnt = 0, ov_cnt = 0, busy_edges = 0;

  always #10 clk_bus = ~clk_bus;            // 50 MHz
  initial begin
    #3;
    forever #12 clk_core = ~clk_core;       // edges never meet bus edges
  end

  rxc_ctrl_sync dut_i (
    .clk_bus_i(clk_bus), .rst_bus_n_i(rst_bus_n),
    .clk_core_i(clk_core), .rst_core_n_i(rst_core_n),
    .wr_en_i(wr_en), .wr_fclr_i(wr_fclr), .wr_rxen_i(wr_rxen), .mod_en_i(mod_en),
    .rd_rxen_o(rd_rxen), .rd_fclr_o(rd_fclr), .sync_busy_o(sync_busy),
    .rx_flush_o(rx_flush), .ovf_clr_o(ovf_clr),
    .core_tx_clr_o(core_tx_clr), .core_rx_clr_o(core_rx_clr), .core_rx_en_o(core_rx_en));

  always @(negedge clk_core) begin
    if (core_tx_clr) tx_cnt++;
    if (core_rx_clr) rx_cnt++;
  end
  always @(posedge clk_core) if (sync_busy) busy_edges++;
  always @(negedge clk_bus) begin
    if (rx_flush) fl_cnt++;
    if (ovf_clr)  ov_cnt++;
  end

  always @(posedge clk_bus) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_counts();
    @(negedge clk_bus);
    tx_cnt = 0; rx_cnt = 0; fl_cnt = 0; ov_cnt = 0; busy_edges = 0;
  endtask

  task automatic do_write(input logic [1:0] f, input logic r, input logic m);
    @(negedge clk_bus);
    mod_en = m; wr_fclr = f; wr_rxen = r; wr_en = 1'b1;
    @(negedge clk_bus);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && sync_busy; k++) @(negedge clk_bus);
  endtask

  initial begin
    repeat (3) @(negedge clk_bus);
    // R1: outputs quiet while held in reset
    chk("R1 rxen in reset", rd_rxen, 0);
    chk("R1 busy in reset", sync_busy, 0);
    rst_bus_n = 1'b1; rst_core_n = 1'b1;
    repeat (6) @(negedge clk_bus);
    chk("R1 rxen", rd_rxen, 0);
    chk("R1 fclr", rd_fclr, 0);
    chk("R1 busy", sync_busy, 0);
    chk("R1 flush", rx_flush | ovf_clr, 0);
    chk("R1 core", core_tx_clr | core_rx_clr | core_rx_en, 0);

    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 4; f++) begin
        for (int r = 0; r < 2; r++) begin
          int exp_busy;
          exp_busy = ((f != 0) || (r == 1 && m == 1)) ? 1 : 0;
          clr_counts();
          do_write(f[1:0], r[0], m[0]);
          // one bus cycle after the write edge
          chk($sformatf("R4/R5/R6 rxen m%0d f%0d r%0d", m, f, r), rd_rxen, r);
          chk($sformatf("R5/R6 busy m%0d f%0d r%0d", m, f, r), sync_busy, exp_busy);
          chk($sformatf("R3 fclr pending m%0d f%0d r%0d", m, f, r), rd_fclr, exp_busy ? f : 0);
          chk($sformatf("R4 flush pulse m%0d f%0d r%0d", m, f, r), rx_flush, r ? 0 : 1);
          chk($sformatf("R4 ovf pulse m%0d f%0d r%0d", m, f, r), ovf_clr, r ? 0 : 1);
          if (r == 0) chk($sformatf("R4 core off m%0d f%0d", m, f), core_rx_en, 0);
          wait_idle();
          chk($sformatf("R3 fclr idle m%0d f%0d r%0d", m, f, r), rd_fclr, 0);
          if (r == 1 && m == 1) chk($sformatf("R6 en at release f%0d", f), core_rx_en, 1);
          if (exp_busy == 1)
            chk($sformatf("R7 busy>=4 edges m%0d f%0d r%0d", m, f, r), busy_edges >= 4, 1);
          repeat (10) @(negedge clk_bus);
          chk($sformatf("R2/R9 tx strobes m%0d f%0d r%0d", m, f, r), tx_cnt, f % 2);
          chk($sformatf("R2/R9 rx strobes m%0d f%0d r%0d", m, f, r), rx_cnt, f / 2);
          chk($sformatf("R4/R9 flush count m%0d f%0d r%0d", m, f, r), fl_cnt, r ? 0 : 1);
          chk($sformatf("R4 ovf count m%0d f%0d r%0d", m, f, r), ov_cnt, r ? 0 : 1);
          chk($sformatf("R10 core level m%0d f%0d r%0d", m, f, r), core_rx_en, r);
          if (exp_busy == 0)
            chk($sformatf("R2 no busy m%0d f%0d r%0d", m, f, r), busy_edges, 0);
        end
      end
    end

    // R8: a disable plus flush issued during busy is dropped
    clr_counts();
    do_write(2'd3, 1'b1, 1'b1);
    chk("R8 busy up", sync_busy, 1);
    do_write(2'd1, 1'b0, 1'b1);
    chk("R8 rxen kept during busy", rd_rxen, 1);
    wait_idle();
    repeat (10) @(negedge clk_bus);
    chk("R8 rxen kept", rd_rxen, 1);
    chk("R8 no flush", fl_cnt + ov_cnt, 0);
    chk("R8 tx once", tx_cnt, 1);
    chk("R8 rx once", rx_cnt, 1);
    chk("R8 core still on", core_rx_en, 1);

    // R10: immediate enable with the module off reaches the core in time
    do_write(2'd0, 1'b0, 1'b0);
    repeat (4) @(negedge clk_bus);
    do_write(2'd0, 1'b1, 1'b0);
    chk("R5 no busy", sync_busy, 0);
    repeat (9) @(negedge clk_bus);   // about 8 core cycles after the write
    chk("R10 core on", core_rx_en, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule